// File: doc/BRIEF.md
# Synchronous Serial Port (Master, 8-bit)

This block is a master-only synchronous serial port that moves one 8-bit word per transfer. It runs on a 4.5 MHz reference clock and divides it down to one of six serial clock rates. Two wiring modes share a single shift register. In 3-wire mode, data leaves on a dedicated output and arrives on a dedicated input, both at once. In 2-wire mode, one bidirectional line either transmits or receives, and the block releases the line while receiving. Software picks the bit order, the wiring mode, the 2-wire direction and the rate through a control register.

Software programs the control register, then writes a byte to the transmit address. That write starts the transfer when the port is idle. The serial clock idles high and falls at the start of each bit. Outgoing data changes only on falling edges, and incoming data is captured on rising edges. When the eighth bit period ends, the received byte appears in the receive register and the block pulses a done interrupt. A transmit write that arrives mid-transfer is dropped and leaves a sticky collision flag behind.

Register map, indexed by the 2-bit bus address:
- 0: control. bit0 selects bit order, 1 for LSB first and 0 for MSB first. bit1 selects wiring, 1 for 2-wire. bit2 selects the 2-wire direction, 1 for receive. bits5:3 hold the rate code.
- 1: transmit.
- 2: receive, read-only.
- 3: status. bit0 is busy and bit1 is collision.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, the following hold:
  - `sclk` is 1, `irqDone` is 0, `sdaOe` is 0 and `sdo` is 1.
  - The control, status and receive registers read as 0.
- R2: A write to address 1 while idle starts an 8-bit transfer. Status bit0 (busy) reads 1 from the clock edge of that write for exactly 16·H cycles, where H is half the divide ratio.
- R3: Control bits5:3 select the divide ratio:

  | Rate code | Divide ratio |
  |---|---|
  | 0 | 360 |
  | 1 | 120 |
  | 2 | 24 |
  | 3 | 16 |
  | 4 | 12 |
  | 5 | 10 |
  | 6 | 10 |
  | 7 | 10 |

  Each bit period holds `sclk` low for H cycles and then high for H cycles. `sclk` is high whenever the port is idle.
- R4: While a transfer runs, the outgoing data bit changes only on a falling edge of `sclk`, never while `sclk` is high or on a rising edge. Incoming data is sampled on the rising edge.
- R5: Control bit0 sets the bit order for both directions. With 0, bit 7 goes first and the first received bit lands in bit 7. With 1, bit 0 goes first and the first received bit lands in bit 0.
- R6: In 3-wire mode (control bit1 = 0), data is sent on `sdo` and received from `sdi`, and `sdaOe` stays 0.
- R7: In 2-wire mode (control bit1 = 1), `sdo` holds 1 and data is received from `sdaIn`.
  - With control bit2 = 0, `sdaOe` is 1 during the transfer and the bits appear on `sdaOut`.
  - With control bit2 = 1, `sdaOe` stays 0.
- R8: When the transfer ends, address 2 returns the 8 received bits.
- R9: `irqDone` is a one-cycle pulse, high in the first cycle after busy clears.
- R10: A write to address 1 while busy has no effect on the running transfer and sets status bit1 (collision). Writing to address 3 with bit1 = 1 clears the flag, and writing 0 there leaves it set.
- R11: Control settings are captured at the start of a transfer. A control write during a transfer is readable at address 0 but takes effect only from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.5 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the addressed register (combinational) |
| sclk | output | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data input, 3-wire mode |
| sdo | output | 1 | Serial data output, 3-wire mode |
| sdaIn | input | 1 | Shared data line as seen at the pad, 2-wire mode |
| sdaOut | output | 1 | Value driven onto the shared data line |
| sdaOe | output | 1 | Drive enable for the shared data line |
| irqDone | output | 1 | One-cycle transfer-done interrupt pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the serial clock is high while idle;
- the outgoing bit holds steady apart from falling edges;
- the done pulse is a single cycle aligned with busy falling;
- a busy-time transmit write raises the collision flag and does not end the transfer;
- the 3-wire output is parked high whenever the shared line is driven.

Other behaviour is visible only in the bench's scenarios:
- the exact transfer length and low time for each rate code;
- the serialized bit order in each mode;
- the received byte;
- that a control write made mid-transfer leaves the current transfer untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Register addresses on the control bus
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_RX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // Control register layout
  localparam int CTRL_W       = 6;
  localparam int CTRL_LSB     = 0;
  localparam int CTRL_TWOWIRE = 1;
  localparam int CTRL_RXDIR   = 2;
  localparam int CTRL_RATE_LO = 3;
  localparam int RATE_W       = 3;

  // Status register layout
  localparam int STAT_BUSY = 0;
  localparam int STAT_COLL = 1;

  // Strobes from the sequencer to the shifter
  typedef struct packed {
    logic load;    // capture transmit byte and configuration
    logic rise;    // sample the incoming bit
    logic fall;    // shift to the next outgoing bit
    logic finish;  // last period over, publish received byte
  } ssp_strobe_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOW,
    S_HIGH
  } ssp_state_t;

  // Half of the reference divide ratio for each rate code
  function automatic int unsigned halfRatio(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    halfRatio = 180;
      3'd1:    halfRatio = 60;
      3'd2:    halfRatio = 12;
      3'd3:    halfRatio = 8;
      3'd4:    halfRatio = 6;
      default: halfRatio = 5;
    endcase
  endfunction

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [CTRL_W-1:0]    cfgWrData,
  input  logic [DATA_W-1:0]    rxData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 cfgLsb,
  output logic                 cfgTwoWire,
  output logic                 cfgRxDir,
  output ssp_strobe_t          strobe,
  output logic                 busy,
  output logic                 sclk,
  output logic                 irqDone
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic              collision;
  ssp_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  halfLim;
  logic [BIT_W-1:0]  bitIdx;

  logic txWrite, startReq, collReq, phaseEnd, lastBit;

  assign txWrite  = busWrEn && (busAddr == ADDR_TX);
  assign startReq = txWrite && !busy;
  assign collReq  = txWrite && busy;
  assign phaseEnd = (state != S_IDLE) && (cnt == halfLim - 1'b1);
  assign lastBit  = (bitIdx == LAST_BIT);

  assign cfgLsb     = ctrlReg[CTRL_LSB];
  assign cfgTwoWire = ctrlReg[CTRL_TWOWIRE];
  assign cfgRxDir   = ctrlReg[CTRL_RXDIR];

  always_comb begin
    strobe.load   = startReq;
    strobe.rise   = phaseEnd && (state == S_LOW);
    strobe.fall   = phaseEnd && (state == S_HIGH) && !lastBit;
    strobe.finish = phaseEnd && (state == S_HIGH) && lastBit;
  end

  // Configuration and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      collision <= 1'b0;
    end else begin
      if (busWrEn && (busAddr == ADDR_CTRL))
        ctrlReg <= cfgWrData;
      if (collReq)
        collision <= 1'b1;
      else if (busWrEn && (busAddr == ADDR_STAT) && cfgWrData[STAT_COLL])
        collision <= 1'b0;
    end
  end

  // Bit-period sequencer and clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sclk    <= 1'b1;
      busy    <= 1'b0;
      cnt     <= '0;
      halfLim <= '1;
      bitIdx  <= '0;
      irqDone <= 1'b0;
    end else begin
      irqDone <= strobe.finish;
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state   <= S_LOW;
            sclk    <= 1'b0;
            busy    <= 1'b1;
            cnt     <= '0;
            bitIdx  <= '0;
            halfLim <= CNT_W'(halfRatio(ctrlReg[CTRL_RATE_LO +: RATE_W]));
          end
        end
        S_LOW: begin
          if (phaseEnd) begin
            state <= S_HIGH;
            sclk  <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (phaseEnd) begin
            cnt <= '0;
            if (lastBit) begin
              state <= S_IDLE;
              busy  <= 1'b0;
            end else begin
              state  <= S_LOW;
              sclk   <= 1'b0;
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          sclk  <= 1'b1;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // Register read mux
  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdData = DATA_W'(ctrlReg);
      ADDR_RX:   busRdData = rxData;
      ADDR_STAT: busRdData = DATA_W'({collision, busy});
      default:   busRdData = '0;
    endcase
  end

  a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk);

  a_r2_start_falls: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sclk);

  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |=> !irqDone);

  a_r9_irq_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> $fell(busy));

  a_r10_collision_set: assert property (@(posedge clk) disable iff (!rstN)
    collReq |=> collision);

  a_r10_transfer_kept: assert property (@(posedge clk) disable iff (!rstN)
    (collReq && !strobe.finish) |=> busy);

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssp_strobe_t       strobe,
  input  logic              active,
  input  logic              cfgLsb,
  input  logic              cfgTwoWire,
  input  logic              cfgRxDir,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  input  logic              sdaIn,
  output logic              sdo,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData
);

  logic              lsbL, twoL, rxDirL;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shifted;
  logic              sampleBit, curBit, inBit;

  // One shifter serves both bit orders; the bit order picks the exit end
  assign curBit  = lsbL ? shReg[0] : shReg[DATA_W-1];
  assign shifted = lsbL ? {sampleBit, shReg[DATA_W-1:1]}
                        : {shReg[DATA_W-2:0], sampleBit};
  assign inBit   = twoL ? sdaIn : sdi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsbL      <= 1'b0;
      twoL      <= 1'b0;
      rxDirL    <= 1'b0;
      shReg     <= '0;
      sampleBit <= 1'b0;
      rxData    <= '0;
    end else begin
      if (strobe.load) begin
        shReg  <= txData;
        lsbL   <= cfgLsb;
        twoL   <= cfgTwoWire;
        rxDirL <= cfgRxDir;
      end
      if (strobe.rise)
        sampleBit <= inBit;
      if (strobe.fall)
        shReg <= shifted;
      if (strobe.finish) begin
        shReg  <= shifted;
        rxData <= shifted;
      end
    end
  end

  // Pin direction control
  assign sdo    = (active && !twoL) ? curBit : 1'b1;
  assign sdaOe  = active && twoL && !rxDirL;
  assign sdaOut = sdaOe ? curBit : 1'b1;

  a_r7_sdo_parked: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> sdo);

  a_r8_rx_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.finish && !strobe.load) |=> $stable(rxData));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              irqDone
);

  ssp_strobe_t       strobe;
  logic              busy;
  logic              cfgLsb, cfgTwoWire, cfgRxDir;
  logic [DATA_W-1:0] rxData;
  logic              txBit;

  ssp_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .cfgWrData  (busWrData[CTRL_W-1:0]),
    .rxData     (rxData),
    .busRdData  (busRdData),
    .cfgLsb     (cfgLsb),
    .cfgTwoWire (cfgTwoWire),
    .cfgRxDir   (cfgRxDir),
    .strobe     (strobe),
    .busy       (busy),
    .sclk       (sclk),
    .irqDone    (irqDone)
  );

  ssp_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .active     (busy),
    .cfgLsb     (cfgLsb),
    .cfgTwoWire (cfgTwoWire),
    .cfgRxDir   (cfgRxDir),
    .txData     (busWrData),
    .sdi        (sdi),
    .sdaIn      (sdaIn),
    .sdo        (sdo),
    .sdaOut     (sdaOut),
    .sdaOe      (sdaOe),
    .rxData     (rxData)
  );

  assign txBit = sdaOe ? sdaOut : sdo;

  a_r4_data_on_falling: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(txBit));

endmodule

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       sclk, sdi, sdo, sdaIn, sdaOut, sdaOe, irqDone;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Slave model: bit sequence in time order is slvPat[7] first
  logic [7:0] slvPat = 8'h00;
  int         slvIdx = 0;
  int         negCnt = 0;
  logic       slvBit;
  assign slvBit = slvPat[7 - slvIdx];
  assign sdi    = slvBit;
  assign sdaIn  = sdaOe ? sdaOut : slvBit;

  // Line capture: word holds the first-sent bit in position 7
  logic       capOn = 1'b0;
  logic       capTwo = 1'b0;
  logic       capExpOe = 1'b0;
  int         capIdx = 0;
  logic [7:0] capWord = 8'h00;
  int         pinBad = 0;

  always @(posedge sclk) begin
    if (capOn && capIdx < 8) begin
      capWord[7 - capIdx] = capTwo ? sdaIn : sdo;
      if (sdaOe !== capExpOe) pinBad++;
      if (capTwo && sdo !== 1'b1) pinBad++;
      capIdx++;
    end
  end

  always @(negedge sclk) begin
    if (capOn) begin
      if (negCnt > 0 && slvIdx < 7) slvIdx++;
      negCnt++;
    end
  end

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdaIn(sdaIn), .sdaOut(sdaOut), .sdaOe(sdaOe), .irqDone(irqDone)
  );

  function automatic int expHalf(input logic [2:0] code);
    case (code)
      3'd0: return 180;
      3'd1: return 60;
      3'd2: return 12;
      3'd3: return 8;
      3'd4: return 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called just after a falling clk edge; returns one cycle later, same phase
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic armCapture(input logic [7:0] ctl, input logic [7:0] slv);
    slvPat = slv; slvIdx = 0; negCnt = 0;
    capIdx = 0; capWord = 8'h00; pinBad = 0;
    capTwo = ctl[1];
    capExpOe = ctl[1] && !ctl[2];
    capOn = 1'b1;
  endtask

  task automatic waitIdle();
    int guard = 0;
    busAddr = 2'd3;
    #1;
    while (busRdData[0] && guard < 20000) begin
      @(negedge clk); #1;
      guard++;
    end
  endtask

  // Full transfer with timing, pin, data and interrupt checks
  task automatic runXfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] slv);
    int busyCnt = 0;
    int lowCnt = 0;
    int earlyIrq = 0;
    int h = expHalf(ctl[5:3]);
    logic [7:0] rd;
    logic [7:0] expRx;
    logic [7:0] expWord;
    busWrite(2'd0, ctl);
    armCapture(ctl, slv);
    busWrite(2'd1, tx);
    busAddr = 2'd3;
    #1;
    while (busRdData[0] && busyCnt < 20000) begin
      busyCnt++;
      if (!sclk) lowCnt++;
      if (irqDone) earlyIrq++;
      @(negedge clk); #1;
    end
    check("R2", "busy cycles", busyCnt, 16 * h);
    check("R3", "sclk low cycles", lowCnt, 8 * h);
    check("R3", "sclk idle high", sclk, 1);
    check("R9", "irq high after busy clears", irqDone, 1);
    check("R9", "irq during busy", earlyIrq, 0);
    @(negedge clk); #1;
    check("R9", "irq one cycle", irqDone, 0);
    check("R6", "rising edges", capIdx, 8);
    check(ctl[1] ? "R7" : "R6", "pin direction errors", pinBad, 0);
    if (!(ctl[1] && ctl[2])) begin
      expWord = ctl[0] ? rev8(tx) : tx;
      check(ctl[0] ? "R5" : "R4", "serialized word", capWord, expWord);
    end
    if (ctl[1] && !ctl[2]) expRx = tx;
    else expRx = ctl[0] ? rev8(slv) : slv;
    busRead(2'd2, rd);
    check("R8", "received byte", rd, expRx);
    capOn = 1'b0;
  endtask

  // {control, transmit, slave pattern}
  localparam logic [23:0] VECS [0:5] = '{
    24'h28_A5_3C,   // rate 5, MSB first, 3-wire
    24'h21_96_81,   // rate 4, LSB first, 3-wire
    24'h1A_C3_00,   // rate 3, MSB first, 2-wire transmit
    24'h17_00_5E,   // rate 2, LSB first, 2-wire receive
    24'h08_7E_E1,   // rate 1, MSB first, 3-wire
    24'h01_1F_F8    // rate 0, LSB first, 3-wire
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "sclk", sclk, 1);
    check("R1", "irqDone", irqDone, 0);
    check("R1", "sdaOe", sdaOe, 0);
    check("R1", "sdo", sdo, 1);
    rstN = 1'b1;
    @(negedge clk);
    busRead(2'd0, rd); check("R1", "control", rd, 0);
    busRead(2'd3, rd); check("R1", "status", rd, 0);
    busRead(2'd2, rd); check("R1", "receive", rd, 0);
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      runXfer(VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]);
      @(negedge clk);
    end

    // R3: rate codes above 5 use the fastest divider
    runXfer(8'h38, 8'h69, 8'h96);
    @(negedge clk);

    // R10: transmit write while busy
    busWrite(2'd0, 8'h28);
    armCapture(8'h28, 8'h00);
    busWrite(2'd1, 8'h5A);
    repeat (10) @(negedge clk);
    busWrite(2'd1, 8'hFF);
    busRead(2'd3, rd); check("R10", "status busy+collision", rd, 3);
    waitIdle();
    @(negedge clk);
    check("R10", "ignored write, word on sdo", capWord, 8'h5A);
    busRead(2'd2, rd); check("R10", "received byte", rd, 8'h00);
    busRead(2'd3, rd); check("R10", "collision sticky after idle", rd, 2);
    capOn = 1'b0;
    @(negedge clk);
    busWrite(2'd3, 8'h00);
    busRead(2'd3, rd); check("R10", "write 0 keeps collision", rd, 2);
    @(negedge clk);
    busWrite(2'd3, 8'h02);
    busRead(2'd3, rd); check("R10", "write 1 clears collision", rd, 0);
    @(negedge clk);

    // R11: control write during a transfer
    busWrite(2'd0, 8'h28);
    armCapture(8'h28, 8'hC5);
    busWrite(2'd1, 8'hB1);
    repeat (7) @(negedge clk);
    busWrite(2'd0, 8'h29);
    waitIdle();
    @(negedge clk);
    check("R11", "order kept mid-transfer", capWord, 8'hB1);
    busRead(2'd2, rd); check("R11", "receive order kept", rd, 8'hC5);
    busRead(2'd0, rd); check("R11", "control readback", rd, 8'h29);
    capOn = 1'b0;
    @(negedge clk);
    runXfer(8'h29, 8'h0D, 8'hB0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule